// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Split Completion

This block gathers a handful of level-sensitive peripheral request lines and presents one interrupt request to a processor core. Each source has an enable bit and a priority. Priority 0 is the most urgent. A source is pending for exactly as long as its line is high and it is enabled. The controller keeps no memory of edges, so it cannot tell a fresh request from a line that simply stayed high.

The core takes an interrupt with an acknowledge read. The read returns the source ID and marks that source active. It also pushes the source's priority onto a small running-priority stack. The request to the core is raised only when a pending, non-active source is strictly more urgent than the top of that stack.

An end-of-interrupt write pops one stack level, which is the priority drop. A deactivate write ends the active state of a source. A mode input selects one of two behaviours. In joint mode the end-of-interrupt write also deactivates the source. In split mode the core can drop priority early, so that less urgent sources can nest, and deactivate later, once the device has been serviced. Raw line status is visible to the core, so it can see when a device has let its line fall.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: `pending_o[i]` equals `line_i[i] & enable_i[i]` in the same cycle. No past line level has any effect.
- R2: While `irq_o` is high, an acknowledge read returns on `ack_id_o`, in the same cycle, the source with the numerically lowest priority among enabled, high-line, non-active sources. A tie goes to the lowest source ID. On the next cycle that source is active and `running_prio_o` equals its priority.
- R3: An acknowledge read while `irq_o` is low returns the spurious ID. The spurious ID is all ones, 2^ID_W-1, which is 7 for four sources. The read changes neither `active_o` nor `running_prio_o`.
- R4: `irq_o` is high only when some enabled, high-line, non-active source has a priority strictly below `running_prio_o`. `running_prio_o` is the top of the stack, or 2^PRIO_W when the stack is empty. An active source is never offered, even while its line is high.
- R5: With `split_mode_i`=0, an end-of-interrupt write of an active ID pops one stack level and clears that source's active bit. A deactivate write has no effect.
- R6: With `split_mode_i`=1, an end-of-interrupt write of an active ID only pops one stack level. A deactivate write of an active ID clears its active bit.
- R7: The following writes change nothing:
  - an end-of-interrupt write whose ID is not active or is out of range;
  - a deactivate write whose ID is not active or is out of range;
  - any end-of-interrupt or deactivate write made in the same cycle as an acknowledge read.
- R8: A source whose enable bit is 0 never raises `irq_o` and is never returned by an acknowledge read.
- R9: If a source's line is high when it is deactivated, or when it is enabled again, the source is offered on the very next cycle. It raises `irq_o` if it outranks the running priority.
- R10: While the stack holds STACK_DEPTH levels, `irq_o` is low whatever the pending sources are.
- R11: `line_status_o` mirrors `line_i` unconditionally, including for disabled and active sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_SRC | Level request lines, synchronous to clk_i |
| enable_i | input | N_SRC | Per-source enable |
| prio_i | input | N_SRC*PRIO_W | Per-source priority, source i at bits i*PRIO_W upward |
| split_mode_i | input | 1 | 1 = priority drop and deactivation are separate writes |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| ack_id_o | output | ID_W | Acknowledged ID, or the spurious ID |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | ID_W | End-of-interrupt write data |
| dir_wr_i | input | 1 | Deactivate write strobe |
| dir_id_i | input | ID_W | Deactivate write data |
| irq_o | output | 1 | Interrupt request to the core |
| pending_o | output | N_SRC | Enabled, asserted sources |
| active_o | output | N_SRC | Active state per source |
| line_status_o | output | N_SRC | Raw line level per source |
| running_prio_o | output | PRIO_W+1 | Top of the running-priority stack, 2^PRIO_W when idle |

## Verification
The bench builds the block with four sources, 3-bit priorities and a stack only two levels deep.

The four sources allow every line pattern to be swept against every enable pattern. This is done under three priority layouts:
- ascending priorities;
- descending priorities;
- all priorities equal.

These three layouts cover ordering, tie-breaking and masking exhaustively.

The shallow stack makes the full-stack cut-off reachable after two nested acknowledges. A directed sequence then covers the remaining behaviours:
- the early drop in split mode;
- lower-priority nesting;
- immediate re-offer on deactivation and on unmasking;
- ignored writes.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic {
    EOI_JOINT = 1'b0,
    EOI_SPLIT = 1'b1
  } eoi_mode_e;
endpackage

// File: rtl/lic_select.sv
module lic_select #(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic [N_SRC-1:0]        cand_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [ID_W-1:0]         best_id_o,
  output logic [PRIO_W:0]         best_prio_o
);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  // strict compare keeps the lowest ID on ties
  always_comb begin
    found_o     = 1'b0;
    best_id_o   = '0;
    best_prio_o = IDLE;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best_prio_o)) begin
        found_o     = 1'b1;
        best_id_o   = ID_W'(i);
        best_prio_o = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
      end
    end
  end
endmodule

// File: rtl/lic_prio_stack.sv
module lic_prio_stack #(
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W:0]   top_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [CW-1:0]     cnt_q;
  logic [PRIO_W-1:0] stk_q [DEPTH];

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               stk_q[g] <= '0;
      else if (push_i && cnt_q == CW'(g))        stk_q[g] <= push_prio_i;
    end
  end

  always_comb begin
    top_o = IDLE;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CW'(i + 1)) top_o = {1'b0, stk_q[i]};
  end
endmodule

// File: rtl/lic_src_state.sv
module lic_src_state #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] active_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       active_o[g] <= 1'b0;
      else if (set_i[g]) active_o[g] <= 1'b1;
      else if (clr_i[g]) active_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  parameter int ID_W        = $clog2(N_SRC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        line_i,
  input  logic [N_SRC-1:0]        enable_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    split_mode_i,
  input  logic                    ack_rd_i,
  output logic [ID_W-1:0]         ack_id_o,
  input  logic                    eoi_wr_i,
  input  logic [ID_W-1:0]         eoi_id_i,
  input  logic                    dir_wr_i,
  input  logic [ID_W-1:0]         dir_id_i,
  output logic                    irq_o,
  output logic [N_SRC-1:0]        pending_o,
  output logic [N_SRC-1:0]        active_o,
  output logic [N_SRC-1:0]        line_status_o,
  output logic [PRIO_W:0]         running_prio_o
);
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  eoi_mode_e         mode;
  logic [N_SRC-1:0]  offer, set_v, clr_v, eoi_sel, dir_sel;
  logic              found, full, empty, take, do_ack, eoi_hit, dir_hit;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W:0]   best_prio;

  assign mode          = eoi_mode_e'(split_mode_i);
  assign line_status_o = line_i;
  assign pending_o     = line_i & enable_i;
  assign offer         = pending_o & ~active_o;

  lic_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
    .cand_i      (offer),
    .prio_i      (prio_i),
    .found_o     (found),
    .best_id_o   (best_id),
    .best_prio_o (best_prio)
  );

  assign take     = found && (best_prio < running_prio_o) && !full;
  assign irq_o    = take;
  assign ack_id_o = take ? best_id : SPUR_ID;
  assign do_ack   = ack_rd_i && take;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      eoi_sel[i] = (eoi_id_i == ID_W'(i));
      dir_sel[i] = (dir_id_i == ID_W'(i));
      set_v[i]   = do_ack && (best_id == ID_W'(i));
    end
  end

  // writes are dropped in a cycle that carries an acknowledge read
  assign eoi_hit = !ack_rd_i && eoi_wr_i && |(eoi_sel & active_o) && !empty;
  assign dir_hit = !ack_rd_i && dir_wr_i && (mode == EOI_SPLIT) && |(dir_sel & active_o);
  assign clr_v   = ((eoi_hit && mode == EOI_JOINT) ? eoi_sel : '0)
                 | (dir_hit ? dir_sel : '0);

  lic_src_state #(.N_SRC(N_SRC)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .active_o (active_o)
  );

  lic_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (do_ack),
    .push_prio_i (best_prio[PRIO_W-1:0]),
    .pop_i       (eoi_hit),
    .top_o       (running_prio_o),
    .full_o      (full),
    .empty_o     (empty)
  );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int N_SRC       = 4,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  parameter int ID_W        = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        line_i,
  input logic [N_SRC-1:0]        enable_i,
  input logic [N_SRC*PRIO_W-1:0] prio_i,
  input logic                    split_mode_i,
  input logic                    ack_rd_i,
  input logic [ID_W-1:0]         ack_id_o,
  input logic                    eoi_wr_i,
  input logic [ID_W-1:0]         eoi_id_i,
  input logic                    dir_wr_i,
  input logic [ID_W-1:0]         dir_id_i,
  input logic                    irq_o,
  input logic [N_SRC-1:0]        pending_o,
  input logic [N_SRC-1:0]        active_o,
  input logic [N_SRC-1:0]        line_status_o,
  input logic [PRIO_W:0]         running_prio_o
);
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  logic [N_SRC-1:0] ack_mask;
  logic [PRIO_W:0]  ack_prio;

  always_comb begin
    ack_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      ack_mask[i] = (ack_id_o == ID_W'(i));
      if (ack_mask[i]) ack_prio = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
    end
  end

  AST_SPUR_WHEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && !irq_o |-> ack_id_o == SPUR_ID); // R3
  AST_SPUR_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && !irq_o |=> $stable(active_o) && $stable(running_prio_o)); // R3
  AST_ACK_LEGAL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && irq_o |-> |(ack_mask & enable_i & line_i & ~active_o)); // R8
  AST_ACK_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && irq_o |=> |(active_o & $past(ack_mask))); // R2
  AST_ACK_PUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && irq_o |=> running_prio_o == $past(ack_prio)); // R2
  AST_ACTIVE_ONLY_BY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_rd_i |=> (active_o & ~$past(active_o)) == '0); // R2
  AST_QUIET_WITHOUT_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i & enable_i & ~active_o) == '0 |-> !irq_o); // R8
  AST_DIR_JOINT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_i && !split_mode_i && !eoi_wr_i && !ack_rd_i |=> $stable(active_o)); // R5
  AST_WRITE_DURING_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && !irq_o && (eoi_wr_i || dir_wr_i) |=> $stable(running_prio_o)); // R7
  AST_STATUS_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_status_o == line_i); // R11
endmodule

bind lvl_irq_ctrl lic_checker #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH), .ID_W(ID_W)
) u_chk (.*);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int D  = 2;
  localparam int IW = 3;
  localparam int SPUR = 7;
  localparam int IDLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line, en;
  logic [N*PW-1:0] prio;
  logic split, ack_rd, eoi_wr, dir_wr;
  logic [IW-1:0] eoi_id, dir_id, ack_id;
  logic irq;
  logic [N-1:0] pend, act, lstat;
  logic [PW:0] run;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(.N_SRC(N), .PRIO_W(PW), .STACK_DEPTH(D), .ID_W(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .enable_i(en), .prio_i(prio),
    .split_mode_i(split), .ack_rd_i(ack_rd), .ack_id_o(ack_id),
    .eoi_wr_i(eoi_wr), .eoi_id_i(eoi_id), .dir_wr_i(dir_wr), .dir_id_i(dir_id),
    .irq_o(irq), .pending_o(pend), .active_o(act), .line_status_o(lstat),
    .running_prio_o(run)
  );

  task automatic chk(string req, int actual, int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_ack(output int id);
    ack_rd = 1'b1; #1; id = int'(ack_id);
    @(posedge clk); @(negedge clk); ack_rd = 1'b0; #1;
  endtask

  task automatic do_eoi(int id);
    eoi_wr = 1'b1; eoi_id = IW'(id);
    @(posedge clk); @(negedge clk); eoi_wr = 1'b0; #1;
  endtask

  task automatic do_dir(int id);
    dir_wr = 1'b1; dir_id = IW'(id);
    @(posedge clk); @(negedge clk); dir_wr = 1'b0; #1;
  endtask

  task automatic set_in(logic [N-1:0] l, logic [N-1:0] e);
    line = l; en = e; #1;
  endtask

  function automatic int pf(int p, int i);
    return (p == 0) ? i : (p == 1) ? 3 - i : 5;
  endfunction

  function automatic int pick(logic [N-1:0] c, int p);
    int best = IDLE, id = SPUR;
    for (int i = 0; i < N; i++)
      if (c[i] && pf(p, i) < best) begin best = pf(p, i); id = i; end
    return id;
  endfunction

  initial begin
    int id, exp_id;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int id, e;
    line = '0; en = '0; prio = '0; split = 1'b0;
    ack_rd = 1'b0; eoi_wr = 1'b0; dir_wr = 1'b0; eoi_id = '0; dir_id = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset irq", int'(irq), 0);
    chk("R3 reset active", int'(act), 0);
    chk("R4 reset running prio idle", int'(run), IDLE);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // sweep: every line and enable pattern under three priority layouts, joint mode
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(pf(p, i));
      for (int l = 0; l < 16; l++) begin
        for (int m = 0; m < 16; m++) begin
          set_in(N'(l), N'(m));
          chk("R1 pending", int'(pend), l & m);
          chk("R11 line status", int'(lstat), l);
          chk("R4 R8 irq", int'(irq), int'((l & m) != 0));
          e = pick(N'(l & m), p);
          do_ack(id);
          chk("R2 R3 R8 ack id", id, e);
          if (e == SPUR) begin
            chk("R3 spurious keeps active", int'(act), 0);
            chk("R3 spurious keeps running", int'(run), IDLE);
          end else begin
            chk("R2 active set", int'(act), 1 << e);
            chk("R2 running pushed", int'(run), pf(p, e));
            do_eoi(e);
            chk("R5 joint eoi deactivates", int'(act), 0);
            chk("R5 joint eoi pops", int'(run), IDLE);
          end
        end
      end
    end

    // directed nesting in split mode: prio src0=4 src1=2 src2=6 src3=0
    prio = {3'd0, 3'd6, 3'd2, 3'd4};
    split = 1'b1;
    set_in(4'b0001, 4'b1111);
    chk("R4 idle offer", int'(irq), 1);
    do_ack(id);
    chk("R2 take src0", id, 0);
    chk("R2 run 4", int'(run), 4);
    set_in(4'b0111, 4'b1111);
    chk("R4 higher preempts", int'(irq), 1);
    do_ack(id);
    chk("R2 take src1", id, 1);
    chk("R2 run 2", int'(run), 2);
    chk("R2 two active", int'(act), 3);
    set_in(4'b1111, 4'b1111);
    chk("R10 stack full quiet", int'(irq), 0);
    do_ack(id);
    chk("R3 R10 spurious when full", id, SPUR);
    chk("R3 active unchanged", int'(act), 3);
    set_in(4'b0110, 4'b1111);
    do_eoi(1);
    chk("R6 split eoi pops", int'(run), 4);
    chk("R6 split eoi keeps active", int'(act), 3);
    chk("R1 active and pending", int'(pend & act), 2);
    chk("R4 lower blocked before drop", int'(irq), 0);
    do_eoi(3);
    chk("R7 eoi inactive id ignored", int'(run), 4);
    do_eoi(6);
    chk("R7 eoi out of range ignored", int'(run), 4);
    do_eoi(0);
    chk("R6 second drop to idle", int'(run), IDLE);
    chk("R4 lower nests after drop", int'(irq), 1);
    do_ack(id);
    chk("R2 take src2", id, 2);
    chk("R2 run 6", int'(run), 6);
    chk("R4 active src1 not offered", int'(irq), 0);
    do_dir(1);
    chk("R6 dir clears", int'(act), 5);
    chk("R9 re-offer on deactivate", int'(irq), 1);
    do_ack(id);
    chk("R9 src1 taken again", id, 1);
    do_dir(3);
    chk("R7 dir inactive id ignored", int'(act), 7);
    do_dir(0);
    do_eoi(1);
    do_dir(1);
    do_eoi(2);
    do_dir(2);
    chk("R6 all deactivated", int'(act), 0);
    chk("R6 stack emptied", int'(run), IDLE);

    // joint mode: deactivate write ignored
    split = 1'b0; #1;
    do_ack(id);
    chk("R2 joint take src1", id, 1);
    do_dir(1);
    chk("R5 dir ignored in joint", int'(act), 2);
    chk("R5 dir no pop", int'(run), 2);
    do_eoi(1);
    chk("R5 eoi deactivates", int'(act), 0);
    chk("R5 eoi pops", int'(run), IDLE);

    // masking and unmask re-offer
    set_in(4'b0010, 4'b1101);
    chk("R8 masked quiet", int'(irq), 0);
    do_ack(id);
    chk("R8 masked not taken", id, SPUR);
    set_in(4'b0010, 4'b1111);
    chk("R9 re-offer on unmask", int'(irq), 1);
    do_ack(id);
    chk("R9 take unmasked", id, 1);

    // write in the same cycle as an acknowledge read is dropped
    set_in(4'b0110, 4'b1111);
    eoi_wr = 1'b1; eoi_id = 3'd1;
    do_ack(id);
    eoi_wr = 1'b0;
    chk("R7 ack spurious", id, SPUR);
    chk("R7 eoi with ack ignored", int'(run), 2);
    chk("R7 active kept", int'(act), 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule